// File: doc/BRIEF.md
# Parallel-Port FIFO DMA Request Controller

This block sits between a host DMA engine and a 16-byte parallel-port FIFO. It decides when to raise the DMA request line. It turns each acknowledge cycle into a one-byte push into the FIFO or a pop out of it. It also holds the service flag, which the terminal-count strobe sets to end a DMA run. No address is decoded: an asserted acknowledge on its own selects the FIFO.

The host picks a transfer direction, clears the service flag and raises the DMA enable. From then on the block requests transfers whenever the FIFO can take or supply a byte. The length of any single request burst is capped, so that memory refresh is never locked out. When terminal count arrives, the block sets the service flag and emits a one-cycle interrupt event. That stops requests until the host clears the flag again.

Top module: `ecpdma_req_ctrl`

## Requirements
- R1: In a reset cycle `rst` is sampled high. After it, `dreq_o`, `fifo_push_o`, `fifo_pop_o` and `irq_evt_o` read 0 and `svc_o` reads 1.
- R2: `dreq_o` can be 1 after a clock edge only if, at that edge, `dma_en_i` was 1 and the service flag's next value was 0.
- R3: When `dir_i`=0 (host to FIFO), a request is made only while `fifo_full_i`=0. When `dir_i`=1 (FIFO to host), a request is made only while `fifo_empty_i`=0. In both cases `dreq_o` follows the condition one clock later.
- R4: An edge with `dack_n_i`=0 and `dma_en_i`=1 gives a one-cycle pulse on the following cycle. The pulse is on `fifo_push_o` when `dir_i`=0 and on `fifo_pop_o` when `dir_i`=1. With `dma_en_i`=0 the acknowledge is ignored and neither strobe pulses.
- R5: An acknowledged cycle is an edge where `dreq_o`=1 and `dack_n_i`=0. After BURST_MAX (default 32) acknowledged cycles in a row, `dreq_o` falls at the edge of the last one. It stays low for exactly one clock and may then rise again.
- R6: If `dma_en_i` is sampled 0, `dreq_o` is 0 after that edge and the burst count is cleared. The next burst is then allowed a full BURST_MAX acknowledged cycles.
- R7: Whenever `dreq_o` has dropped for any reason, such as the FIFO being full or empty, the burst count restarts from zero.
- R8: If `tc_i`=1 while `dma_en_i`=1 and the service flag is 0, then after that edge `svc_o`=1, `irq_evt_o` pulses for one cycle and `dreq_o`=0. If the flag is already 1, `tc_i` is ignored and no event is produced.
- R9: When `svc_wr_i`=1, `svc_o` takes `svc_wdata_i` at the edge. An accepted terminal count in the same cycle wins and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en_i | input | 1 | DMA enable from host |
| svc_wr_i | input | 1 | Host write strobe for the service flag |
| svc_wdata_i | input | 1 | Value written to the service flag |
| dir_i | input | 1 | 0 = host to FIFO, 1 = FIFO to host |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| dack_n_i | input | 1 | DMA acknowledge, active low |
| tc_i | input | 1 | Terminal-count strobe |
| dreq_o | output | 1 | DMA request |
| svc_o | output | 1 | Service flag |
| irq_evt_o | output | 1 | One-cycle interrupt event on terminal count |
| fifo_push_o | output | 1 | Write one byte into the FIFO |
| fifo_pop_o | output | 1 | Read one byte from the FIFO |

## Verification
The assertions assume that synchronous reset is held high at time zero. They also assume that the FIFO flags and the acknowledge are steady around each rising edge. They do not assume that the acknowledge only comes while a request is up. The stimulus drives every input shortly after a rising edge and samples just after the next one. It keeps full and empty mutually exclusive and asserts the acknowledge even while the request is low, to show that such a cycle moves a byte but does not count toward a burst.

// File: rtl/ecpdma_pkg.sv
package ecpdma_pkg;
  typedef enum logic {
    DIR_TO_FIFO   = 1'b0,
    DIR_FROM_FIFO = 1'b1
  } xfer_dir_e;

  function automatic logic fifo_ready(input xfer_dir_e d, input logic full, input logic empty);
    return (d == DIR_TO_FIFO) ? !full : !empty;
  endfunction
endpackage

// File: rtl/ecpdma_svc_flag.sv
module ecpdma_svc_flag (
  input  logic clk,
  input  logic rst,
  input  logic dma_en_i,
  input  logic tc_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic svc_next_o,
  output logic svc_o,
  output logic irq_evt_o
);
  logic svc_q;
  logic tc_take;

  assign tc_take = tc_i && dma_en_i && !svc_q;

  always_comb begin
    if (tc_take)   svc_next_o = 1'b1;
    else if (wr_i) svc_next_o = wdata_i;
    else           svc_next_o = svc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q     <= 1'b1;
      irq_evt_o <= 1'b0;
    end else begin
      svc_q     <= svc_next_o;
      irq_evt_o <= tc_take;
    end
  end

  assign svc_o = svc_q;

  a_r8_tc_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (tc_i && dma_en_i && !svc_o) |=> (svc_o && irq_evt_o));
  a_r8_evt_single: assert property (@(posedge clk) disable iff (rst)
    irq_evt_o |=> !irq_evt_o);
endmodule

// File: rtl/ecpdma_burst_ctr.sv
module ecpdma_burst_ctr #(
  parameter int BURST_MAX = 32,
  localparam int CNT_W = $clog2(BURST_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_limit_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BURST_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (clr_i)      cnt_n = '0;
    else if (inc_i) cnt_n = cnt_q + 1'b1;
    else            cnt_n = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  assign at_limit_o = (cnt_n == LIMIT);
  assign cnt_o      = cnt_q;

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/ecpdma_xfer_strobe.sv
module ecpdma_xfer_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ack_i,
  input  logic dir_i,
  output logic push_o,
  output logic pop_o
);
  import ecpdma_pkg::*;

  xfer_dir_e dir;
  assign dir = xfer_dir_e'(dir_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      push_o <= 1'b0;
      pop_o  <= 1'b0;
    end else begin
      push_o <= ack_i && (dir == DIR_TO_FIFO);
      pop_o  <= ack_i && (dir == DIR_FROM_FIFO);
    end
  end

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_o, pop_o}));
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> !(push_o || pop_o));
endmodule

// File: rtl/ecpdma_req_ctrl.sv
module ecpdma_req_ctrl #(
  parameter int BURST_MAX = 32,
  localparam int CNT_W = $clog2(BURST_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic dma_en_i,
  input  logic svc_wr_i,
  input  logic svc_wdata_i,
  input  logic dir_i,
  input  logic fifo_full_i,
  input  logic fifo_empty_i,
  input  logic dack_n_i,
  input  logic tc_i,
  output logic dreq_o,
  output logic svc_o,
  output logic irq_evt_o,
  output logic fifo_push_o,
  output logic fifo_pop_o
);
  import ecpdma_pkg::*;

  logic             svc_next;
  logic             at_limit;
  logic [CNT_W-1:0] burst_cnt;
  logic             dreq_q;
  logic             ready;
  logic             burst_ack;

  ecpdma_svc_flag u_svc (
    .clk        (clk),
    .rst        (rst),
    .dma_en_i   (dma_en_i),
    .tc_i       (tc_i),
    .wr_i       (svc_wr_i),
    .wdata_i    (svc_wdata_i),
    .svc_next_o (svc_next),
    .svc_o      (svc_o),
    .irq_evt_o  (irq_evt_o)
  );

  // A burst counts only acknowledges that answer a live request.
  assign burst_ack = dreq_q && !dack_n_i;

  ecpdma_burst_ctr #(.BURST_MAX(BURST_MAX)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (!dreq_q || !dma_en_i),
    .inc_i      (burst_ack),
    .cnt_o      (burst_cnt),
    .at_limit_o (at_limit)
  );

  ecpdma_xfer_strobe u_strb (
    .clk    (clk),
    .rst    (rst),
    .ack_i  (!dack_n_i && dma_en_i),
    .dir_i  (dir_i),
    .push_o (fifo_push_o),
    .pop_o  (fifo_pop_o)
  );

  assign ready = fifo_ready(xfer_dir_e'(dir_i), fifo_full_i, fifo_empty_i);

  always_ff @(posedge clk) begin
    if (rst) dreq_q <= 1'b0;
    else     dreq_q <= dma_en_i && !svc_next && ready && !at_limit;
  end

  assign dreq_o = dreq_q;

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!dreq_o && svc_o && !irq_evt_o && !fifo_push_o && !fifo_pop_o));
  a_r2_no_req_in_service: assert property (@(posedge clk) disable iff (rst)
    !(dreq_o && svc_o));
  a_r3_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (!dir_i && fifo_full_i) |=> !dreq_o);
  a_r3_empty_blocks: assert property (@(posedge clk) disable iff (rst)
    (dir_i && fifo_empty_i) |=> !dreq_o);
  a_r5_burst_cap: assert property (@(posedge clk) disable iff (rst)
    (dreq_o && !dack_n_i && dma_en_i && burst_cnt == CNT_W'(BURST_MAX - 1)) |=> !dreq_o);
  a_r6_enable_drop: assert property (@(posedge clk) disable iff (rst)
    !dma_en_i |=> !dreq_o);
endmodule

// File: tb/test_ecpdma_req_ctrl.sv
module test_ecpdma_req_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_en, svc_wr, svc_wd, dir, full, empty, dack_n, tc;
  logic dreq, svc, irq, push, pop;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  ecpdma_req_ctrl i_ecpdma_req_ctrl (
    .clk(clk), .rst(rst), .dma_en_i(dma_en), .svc_wr_i(svc_wr), .svc_wdata_i(svc_wd),
    .dir_i(dir), .fifo_full_i(full), .fifo_empty_i(empty), .dack_n_i(dack_n), .tc_i(tc),
    .dreq_o(dreq), .svc_o(svc), .irq_evt_o(irq), .fifo_push_o(push), .fifo_pop_o(pop)
  );

  // inputs {en,wr,wd,dir,full,empty,dack_n,tc} , expected {dreq,svc,push,pop,irq}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {8'b01000110, 5'b00000},  // R9 clear flag, enable off -> R2 no request
    {8'b10000110, 5'b10000},  // R2 request, dir0 not full
    {8'b10000100, 5'b10100},  // R4 push strobe
    {8'b10001010, 5'b00000},  // R3 full blocks
    {8'b10010110, 5'b00000},  // R3 empty blocks dir1
    {8'b10010010, 5'b10000},  // R3 not empty
    {8'b10010000, 5'b10010},  // R4 pop strobe
    {8'b00010000, 5'b00000},  // R4 ack ignored, R6 drop
    {8'b10010010, 5'b10000},
    {8'b10010001, 5'b01011},  // R8 terminal count
    {8'b10010010, 5'b01000},
    {8'b10010011, 5'b01000},  // R8 tc ignored while set
    {8'b11010010, 5'b10000},  // R9 host clear
    {8'b11010011, 5'b01001},  // R9 tc wins over write
    {8'b11110010, 5'b01000},  // R9 host set
    {8'b11010010, 5'b10000}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Hold acknowledge low until the request falls; returns acks taken.
  task automatic acks_until_drop(output int n);
    n = 0;
    for (int k = 1; k <= 40; k++) begin
      dack_n = 1'b0;
      step();
      if (!dreq) begin
        n = k;
        break;
      end
    end
    dack_n = 1'b1;
  endtask

  task automatic ack_n(input int cnt, output bit stayed);
    stayed = 1'b1;
    for (int k = 0; k < cnt; k++) begin
      dack_n = 1'b0;
      step();
      if (!dreq) stayed = 1'b0;
    end
    dack_n = 1'b1;
  endtask

  initial begin
    int  got;
    bit  ok;
    dma_en = 0; svc_wr = 0; svc_wd = 0; dir = 0; full = 0; empty = 1; dack_n = 1; tc = 0;
    step(); step();
    chk("R1 dreq", dreq, 0);
    chk("R1 svc", svc, 1);
    chk("R1 strobes", {push, pop, irq}, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {dma_en, svc_wr, svc_wd, dir, full, empty, dack_n, tc} = VEC[i][12:5];
      step();
      chk($sformatf("vec%0d R2/R3/R4/R8/R9", i), {dreq, svc, push, pop, irq}, VEC[i][4:0]);
    end
    svc_wr = 0; tc = 0; dack_n = 1;

    // R5: burst cap with one idle clock
    acks_until_drop(got);
    chk("R5 burst length", got, 32);
    step();
    chk("R5 one idle clock then reassert", dreq, 1);

    // R7: pause on empty restarts count
    ack_n(20, ok);
    chk("R7 first part held", ok, 1);
    empty = 1; step();
    chk("R7 empty drops request", dreq, 0);
    empty = 0; step();
    chk("R7 reassert", dreq, 1);
    acks_until_drop(got);
    chk("R7 full burst after pause", got, 32);
    step();

    // R6: enable drop clears count
    ack_n(10, ok);
    dma_en = 0; step();
    chk("R6 request drops", dreq, 0);
    dma_en = 1; step();
    chk("R6 reassert", dreq, 1);
    acks_until_drop(got);
    chk("R6 full burst after disable", got, 32);

    // R4: ack while request low still moves a byte
    dir = 1; empty = 1; step();
    dack_n = 0; step(); dack_n = 1;
    chk("R4 pop without request", pop, 1);
    step();
    chk("R4 pop single cycle", pop, 0);

    // R1: reset mid-run
    empty = 0; step();
    rst = 1; step(); rst = 0;
    chk("R1 reset dreq", dreq, 0);
    chk("R1 reset svc", svc, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule